// File: doc/BRIEF.md
# Configurable Pad Interface Cell

This block is the logic core of a configurable I/O cell. It sits between a package pad and the internal fabric, for a group of `WIDTH` pads that share one set of configuration bits. On the input side the pad value reaches the fabric in two ways at once: as a plain wire and through a storage element. That element works either as an edge-triggered flip-flop or as a level-sensitive latch. On the output side the pad value comes either from an output flip-flop or straight from the fabric. The value and the drive enable can each be inverted.

Configuration bits are static inputs. They are expected to change only while `cfg_busy_i` is high, and that signal also holds every storage element cleared. One clock-sense bit is shared by the input and output storage. Each storage element picks one of two clock lines with its own select bit. The analog side of the pad (thresholds, slew, pull-ups, protection) is outside this block. An external pad driver uses `pad_o` and `pad_oe_o`, and presents high impedance when `pad_oe_o` is low.

Top module: `io_cell`

## Requirements
- R1: `direct_o` equals `pad_i` at all times, in every configuration.
- R2: With `cfg_in_latch_i`=0, `registered_o` takes `pad_i` on the rising edge of the selected input clock when `cfg_clk_inv_i`=0, and on the falling edge when `cfg_clk_inv_i`=1. It holds between those edges.
- R3: With `cfg_in_latch_i`=1, `registered_o` follows `pad_i` while the selected input clock is low (`cfg_clk_inv_i`=0) or high (`cfg_clk_inv_i`=1). It holds its value in the opposite phase.
- R4: `cfg_in_sel_i`=0 selects `clk_a_i` as the input clock and 1 selects `clk_b_i`. `cfg_out_sel_i` selects the output clock the same way, independently.
- R5: The output flip-flop captures `core_out_i`, before any inversion. It captures on the rising edge of the selected output clock when `cfg_clk_inv_i`=0, and on the falling edge when it is 1.
- R6: With `cfg_out_reg_i`=1, `pad_o` is taken from the output flip-flop. With 0, it is taken combinationally from `core_out_i`.
- R7: With `cfg_out_inv_i`=1, `pad_o` is the bitwise inverse of the value chosen by R6.
- R8: `pad_oe_o` equals `core_oe_i` XOR `cfg_oe_inv_i`. A 1 means the pad drives, and a 0 means high impedance.
- R9: While `rst_ni` is low, the input and output storage are cleared asynchronously to 0. This holds even in the middle of a transparent latch phase, and storage resumes from the pad as soon as reset ends.
- R10: While `cfg_busy_i` is high, all storage is cleared exactly as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | First clock line |
| clk_b_i | input | 1 | Second clock line |
| rst_ni | input | 1 | Active-low asynchronous chip reset |
| cfg_busy_i | input | 1 | Configuration in progress; clears storage |
| cfg_in_latch_i | input | 1 | 1: input element is a latch, 0: flip-flop |
| cfg_clk_inv_i | input | 1 | Shared clock-sense inversion |
| cfg_in_sel_i | input | 1 | Input clock select (0 a, 1 b) |
| cfg_out_sel_i | input | 1 | Output clock select (0 a, 1 b) |
| cfg_out_reg_i | input | 1 | 1: registered output, 0: direct |
| cfg_out_inv_i | input | 1 | Invert output data |
| cfg_oe_inv_i | input | 1 | Invert drive enable |
| pad_i | input | WIDTH | Value seen at the pads |
| core_out_i | input | WIDTH | Output data from the fabric |
| core_oe_i | input | WIDTH | Drive control from the fabric |
| direct_o | output | WIDTH | Unstored pad input |
| registered_o | output | WIDTH | Stored pad input |
| pad_o | output | WIDTH | Value to the pad driver |
| pad_oe_o | output | WIDTH | Pad driver enable, active high |

## Verification
The bench builds the cell with `WIDTH` = 4 and drives random 4-bit patterns, so a fault that couples bits or handles only one bit shows up as a mismatch. It walks through all 128 settings of the seven configuration bits. This covers both storage modes, both clock senses and both choices of each clock line, and every output and enable polarity. The two clock lines toggle at different rates, so a swapped clock select produces wrong capture times. A dedicated sequence asserts reset while the latch is transparent, cycles both clocks during reset, and then releases reset to show the latch picking the pad value up again.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;
  typedef struct packed {
    logic in_latch;
    logic clk_inv;
    logic in_sel;
    logic out_sel;
    logic out_reg;
    logic out_inv;
    logic oe_inv;
  } io_cfg_t;
endpackage

// File: rtl/io_clk_sel.sv
module io_clk_sel (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_i,
  input  logic inv_i,
  output logic clk_o
);
  assign clk_o = (sel_i ? clk_b_i : clk_a_i) ^ inv_i;
endmodule

// File: rtl/io_in_store.sv
module io_in_store #(
  parameter int WIDTH = 4
) (
  input  logic             ck_i,
  input  logic             clr_ni,
  input  logic             latch_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] ff_q;
  logic [WIDTH-1:0] lat_q;

  always_ff @(posedge ck_i or negedge clr_ni) begin
    if (!clr_ni) ff_q <= '0;
    else         ff_q <= d_i;
  end

  // open while the (sense-corrected) clock is low
  always_latch begin
    if (!clr_ni)    lat_q = '0;
    else if (!ck_i) lat_q = d_i;
  end

  assign q_o = latch_i ? lat_q : ff_q;

  // R2
  in_ff_cap_chk: assert property (@(posedge ck_i) disable iff (!clr_ni)
    1'b1 |=> ff_q == $past(d_i));

  // R3
  lat_close_chk: assert property (@(posedge ck_i) disable iff (!clr_ni)
    lat_q == d_i);

  // R9 R10
  always @(posedge ck_i) begin
    if (!clr_ni) in_clr_chk: assert (ff_q == '0 && lat_q == '0);
  end
endmodule

// File: rtl/io_out_path.sv
module io_out_path #(
  parameter int WIDTH = 4
) (
  input  logic             ck_i,
  input  logic             clr_ni,
  input  logic             reg_sel_i,
  input  logic             out_inv_i,
  input  logic             oe_inv_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] oe_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  logic [WIDTH-1:0] out_q;

  always_ff @(posedge ck_i or negedge clr_ni) begin
    if (!clr_ni) out_q <= '0;
    else         out_q <= d_i;
  end

  assign pad_o    = (reg_sel_i ? out_q : d_i) ^ {WIDTH{out_inv_i}};
  assign pad_oe_o = oe_i ^ {WIDTH{oe_inv_i}};

  // R5
  out_ff_cap_chk: assert property (@(posedge ck_i) disable iff (!clr_ni)
    1'b1 |=> out_q == $past(d_i));

  // R9 R10
  always @(posedge ck_i) begin
    if (!clr_ni) out_clr_chk: assert (out_q == '0);
  end
endmodule

// File: rtl/io_cell.sv
module io_cell #(
  parameter int WIDTH = 4
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             rst_ni,
  input  logic             cfg_busy_i,
  input  logic             cfg_in_latch_i,
  input  logic             cfg_clk_inv_i,
  input  logic             cfg_in_sel_i,
  input  logic             cfg_out_sel_i,
  input  logic             cfg_out_reg_i,
  input  logic             cfg_out_inv_i,
  input  logic             cfg_oe_inv_i,
  input  logic [WIDTH-1:0] pad_i,
  input  logic [WIDTH-1:0] core_out_i,
  input  logic [WIDTH-1:0] core_oe_i,
  output logic [WIDTH-1:0] direct_o,
  output logic [WIDTH-1:0] registered_o,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  import io_cell_pkg::*;

  io_cfg_t cfg;
  logic    clr_n;
  logic    in_ck;
  logic    out_ck;

  assign cfg = '{in_latch: cfg_in_latch_i, clk_inv: cfg_clk_inv_i,
                 in_sel: cfg_in_sel_i, out_sel: cfg_out_sel_i,
                 out_reg: cfg_out_reg_i, out_inv: cfg_out_inv_i,
                 oe_inv: cfg_oe_inv_i};

  assign clr_n    = rst_ni & ~cfg_busy_i;
  assign direct_o = pad_i;

  io_clk_sel u_in_ck (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .sel_i   (cfg.in_sel),
    .inv_i   (cfg.clk_inv),
    .clk_o   (in_ck)
  );

  io_clk_sel u_out_ck (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .sel_i   (cfg.out_sel),
    .inv_i   (cfg.clk_inv),
    .clk_o   (out_ck)
  );

  io_in_store #(.WIDTH(WIDTH)) u_in (
    .ck_i    (in_ck),
    .clr_ni  (clr_n),
    .latch_i (cfg.in_latch),
    .d_i     (pad_i),
    .q_o     (registered_o)
  );

  io_out_path #(.WIDTH(WIDTH)) u_out (
    .ck_i      (out_ck),
    .clr_ni    (clr_n),
    .reg_sel_i (cfg.out_reg),
    .out_inv_i (cfg.out_inv),
    .oe_inv_i  (cfg.oe_inv),
    .d_i       (core_out_i),
    .oe_i      (core_oe_i),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o)
  );
endmodule

// File: tb/io_cell_test.sv
module io_cell_test;
  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;

  logic clk_a = 0, clk_b = 0, rst_n = 0, busy = 0;
  logic c_latch = 0, c_inv = 0, c_isel = 0, c_osel = 0;
  logic c_oreg = 0, c_oinv = 0, c_oeinv = 0;
  logic [W-1:0] pad = '0, cout = '0, coe = '0;
  logic [W-1:0] direct, registered, pado, padoe;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_ff = '0, m_lat = '0, m_out = '0;
  logic prev_in = 0, prev_out = 0;

  io_cell #(.WIDTH(W)) uut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n), .cfg_busy_i(busy),
    .cfg_in_latch_i(c_latch), .cfg_clk_inv_i(c_inv), .cfg_in_sel_i(c_isel),
    .cfg_out_sel_i(c_osel), .cfg_out_reg_i(c_oreg), .cfg_out_inv_i(c_oinv),
    .cfg_oe_inv_i(c_oeinv), .pad_i(pad), .core_out_i(cout), .core_oe_i(coe),
    .direct_o(direct), .registered_o(registered), .pad_o(pado), .pad_oe_o(padoe)
  );

  function automatic logic eff(logic sel);
    return (sel ? clk_b : clk_a) ^ c_inv;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update after the bench has changed its signals, then check mid-period
  task automatic ev();
    logic ni, no, clr;
    logic [W-1:0] exp_pad;
    string rtag;
    ni  = eff(c_isel);
    no  = eff(c_osel);
    clr = !rst_n || busy;
    if (clr) begin
      m_ff = '0; m_lat = '0; m_out = '0;
    end else begin
      if (ni && !prev_in)  m_ff  = pad;
      if (no && !prev_out) m_out = cout;
      if (!ni)             m_lat = pad;
    end
    prev_in  = ni;
    prev_out = no;
    #(CLK_PERIOD/2);
    if (!rst_n)       rtag = "R9";
    else if (busy)    rtag = "R10";
    else if (c_latch) rtag = "R3 R4";
    else              rtag = "R2 R4";
    exp_pad = (c_oreg ? m_out : cout) ^ {W{c_oinv}};
    chk("R1 direct", direct, pad);
    chk({rtag, " registered"}, registered, c_latch ? m_lat : m_ff);
    chk(c_oreg ? "R5 R6 R7 pad" : "R6 R7 pad", pado, exp_pad);
    chk("R8 oe", padoe, coe ^ {W{c_oeinv}});
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    ev();                                   // R9 reset state
    rst_n = 1; ev();
    for (int k = 0; k < 128; k++) begin
      busy = 1; ev();                       // R10
      {c_latch, c_inv, c_isel, c_osel, c_oreg, c_oinv, c_oeinv} = k[6:0];
      ev();
      clk_a = ~clk_a; ev(); clk_b = ~clk_b; ev();
      clk_a = ~clk_a; ev(); clk_b = ~clk_b; ev();
      busy = 0; ev();
      for (int i = 0; i < 6; i++) begin
        pad = W'($urandom); ev();
        clk_a = ~clk_a; ev();
        cout = W'($urandom); coe = W'($urandom); ev();
        pad = W'($urandom); ev();
        clk_b = ~clk_b; ev();
        if (i % 2 == 0) begin clk_a = ~clk_a; ev(); end
      end
    end

    // R9: reset during a transparent latch phase
    busy = 1; ev();
    {c_latch, c_inv, c_isel, c_osel, c_oreg, c_oinv, c_oeinv} = 7'b1000100;
    clk_a = 0; clk_b = 0; ev();
    busy = 0; ev();
    pad = 4'hA; ev();                       // R3 follows
    chk("R3 transparent follow", registered, 4'hA);
    rst_n = 0; ev();
    chk("R9 cleared mid-transparent", registered, 4'h0);
    clk_a = 1; ev(); clk_b = 1; ev(); clk_a = 0; ev(); clk_b = 0; ev();
    rst_n = 1; ev();
    chk("R9 resumes after reset", registered, 4'hA);
    clk_a = 1; ev();
    pad = 4'h5; ev();
    chk("R3 opaque hold", registered, 4'hA);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule